// File: doc/BRIEF.md
# Vendor configuration command decoder for bulk command wrappers

This block watches a byte stream that carries 31-byte bulk command wrappers. Each byte arrives with a valid strobe, and the final byte of a frame also carries a last marker. As the bytes go by, the decoder pulls out the signature, the 32-bit data length, the direction flag and the 16-byte command block, and checks them on the fly.

It then decides whether the command block holds a configuration-memory load or read command. When it does, one clock after the final byte it gives one of three results:

- a one-cycle command pulse, together with the direction and the transfer length;
- a one-cycle error pulse, when the frame is malformed or asks for something the command cannot do;
- nothing at all, when the command block belongs to a different command set.

The expected designator byte comes in on a port, so that the surrounding logic can set it from its configuration data. The data phase, the status reply and the memory access itself are left to other blocks.

The frame is tracked by a three-state machine:

- `ST_IDLE` waits for byte 0.
- `ST_BODY` counts bytes 1 to 30.
- `ST_FLUSH` discards the tail of an over-long frame.

The transitions are:

- `ST_IDLE` to `ST_BODY` on a byte without last.
- `ST_IDLE` to itself, with an error, on a byte that carries last.
- `ST_BODY` to `ST_IDLE` on a byte with last, giving the verdict.
- `ST_BODY` to `ST_FLUSH`, with an error, when byte 30 arrives without last.
- `ST_FLUSH` to `ST_IDLE` on the byte with last.

Top module: `cbw_cfg_decoder`

## Requirements
- R1: After reset, `cmd_valid`, `cmd_err` and `cmd_read` are 0 and `cmd_len` is 0.
- R2: A well-formed configuration command of exactly 31 bytes gives `cmd_valid` high for exactly one cycle. That cycle is the one after the clock edge that accepts byte 30 with `in_last`, and `cmd_err` stays low.
- R3: Bit 7 of byte 12 sets the direction. A value of 1 means device-to-host and gives `cmd_read` = 1. A value of 0 gives `cmd_read` = 0. `cmd_read` is presented with the pulse and held until the next one.
- R4: Bytes 8 to 11 hold the transfer length, least significant byte first, and it appears on `cmd_len` with the pulse. A length of `MAX_LEN` (255) is accepted. Any larger value gives `cmd_err` instead, including a value whose only nonzero byte is byte 11.
- R5: Bytes 0 to 3 must read 0x55, 0x53, 0x42, 0x43 (the value 0x43425355, least significant byte first). Any other value gives `cmd_err` and no pulse.
- R6: If `in_last` arrives on any byte before byte 30, the block gives `cmd_err` one cycle after that byte and no `cmd_valid`. This includes a single-byte frame.
- R7: If byte 30 arrives without `in_last`, the block gives `cmd_err` one cycle after byte 30. The bytes that follow, up to and including the next `in_last`, give no further output, and the frame after them is decoded normally.
- R8: If byte 15 (command block byte 0) differs from `vend_code`, the frame is not this block's command. It gives neither `cmd_valid` nor `cmd_err`.
- R9: When byte 15 matches, the frame is rejected with `cmd_err` if any of these fails:
  - byte 16 equals 0x26;
  - byte 17 equals 0;
  - byte 18 equals 0x02;
  - bytes 19 and 20 (start address) equal 0;
  - bytes 21 to 30 equal 0.
- R10: Cycles with `in_valid` low are ignored. Gaps between bytes do not change the result, and no output pulse follows a cycle with `in_valid` low.
- R11: The tag (bytes 4 to 7), the unit number (byte 13) and the block-length byte (byte 14) have no effect on the result.
- R12: `cmd_valid` and `cmd_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_data | input | 8 | Wrapper byte |
| in_last | input | 1 | This byte ends the frame |
| vend_code | input | 8 | Expected designator for command block byte 0 |
| cmd_valid | output | 1 | One-cycle pulse: an accepted configuration command |
| cmd_read | output | 1 | 1 = memory read (device-to-host), 0 = load |
| cmd_len | output | LEN_W | Transfer length of the accepted command |
| cmd_err | output | 1 | One-cycle pulse: malformed or unsupported frame |

## Verification
The bench builds the decoder with its default parameters: a `MAX_LEN` of 255 (so `LEN_W` is 8), opcode 0x26 and memory-source code 0x02. With a 255-byte cap, both edges of the length check can be reached with real frames: 255 passes, while 256 and a length whose only nonzero byte is the top one are rejected. Because the frame size is fixed at 31 bytes, every early, exact and late position of the last marker can be driven in a short run. The same holds for corrupting each constrained command-block byte in turn.

// File: rtl/cbw_cfg_pkg.sv
`timescale 1ns/1ps
package cbw_cfg_pkg;
    localparam int FRAME_BYTES = 31;
    localparam int IDX_W       = $clog2(FRAME_BYTES);
    localparam int CB_BASE     = 15;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_FLUSH
    } state_t;

    typedef enum logic [1:0] {
        V_NONE,
        V_OK,
        V_ERR
    } verdict_t;

    typedef struct packed {
        logic        sig_bad;
        logic        desig_bad;
        logic        field_bad;
        logic        dir_rd;
        logic [31:0] len;
    } frame_flags_t;
endpackage

// File: rtl/cbw_field_check.sv
`timescale 1ns/1ps
module cbw_field_check
    import cbw_cfg_pkg::*;
#(
    parameter logic [31:0] SIGNATURE  = 32'h43425355,
    parameter logic [7:0]  CFG_OPCODE = 8'h26,
    parameter logic [7:0]  MEM_SRC    = 8'h02
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       data,
    input  logic [7:0]       designator,
    output frame_flags_t     flags_nxt
);
    frame_flags_t acc;
    frame_flags_t base;
    int unsigned  pos;

    always_comb begin
        pos       = 32'(idx);
        base      = (idx == '0) ? '0 : acc;
        flags_nxt = base;
        if (pos < 4) begin
            if (data != SIGNATURE[8*pos +: 8]) flags_nxt.sig_bad = 1'b1;
        end else if (pos >= 8 && pos <= 11) begin
            flags_nxt.len[8*(pos-8) +: 8] = data;
        end else if (pos == 12) begin
            flags_nxt.dir_rd = data[7];
        end else if (pos == CB_BASE) begin
            if (data != designator) flags_nxt.desig_bad = 1'b1;
        end else if (pos == CB_BASE + 1) begin
            if (data != CFG_OPCODE) flags_nxt.field_bad = 1'b1;
        end else if (pos == CB_BASE + 3) begin
            if (data != MEM_SRC) flags_nxt.field_bad = 1'b1;
        end else if (pos > CB_BASE + 1) begin
            if (data != 8'h00) flags_nxt.field_bad = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    acc <= '0;
        else if (take) acc <= flags_nxt;
    end
endmodule

// File: rtl/cbw_frame_fsm.sv
`timescale 1ns/1ps
module cbw_frame_fsm
    import cbw_cfg_pkg::*;
#(
    parameter int MAX_LEN = 255,
    parameter int LEN_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  frame_flags_t     flags_nxt,
    output logic [IDX_W-1:0] idx,
    output logic             cmd_valid,
    output logic             cmd_err,
    output logic             cmd_read,
    output logic [LEN_W-1:0] cmd_len
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

    state_t           state, state_nxt;
    logic [IDX_W-1:0] idx_nxt;
    verdict_t         verdict, judge;

    always_comb begin
        if (idx != LAST_IDX)                                 judge = V_ERR;
        else if (flags_nxt.sig_bad)                          judge = V_ERR;
        else if (flags_nxt.desig_bad)                        judge = V_NONE;
        else if (flags_nxt.field_bad ||
                 flags_nxt.len > 32'(MAX_LEN))               judge = V_ERR;
        else                                                 judge = V_OK;
    end

    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        verdict   = V_NONE;
        if (in_valid) begin
            unique case (state)
                ST_IDLE: begin
                    if (in_last) verdict = V_ERR;
                    else begin
                        state_nxt = ST_BODY;
                        idx_nxt   = IDX_W'(1);
                    end
                end
                ST_BODY: begin
                    if (in_last) begin
                        state_nxt = ST_IDLE;
                        idx_nxt   = '0;
                        verdict   = judge;
                    end else if (idx == LAST_IDX) begin
                        state_nxt = ST_FLUSH;
                        verdict   = V_ERR;
                    end else begin
                        idx_nxt = idx + IDX_W'(1);
                    end
                end
                ST_FLUSH: begin
                    if (in_last) begin
                        state_nxt = ST_IDLE;
                        idx_nxt   = '0;
                    end
                end
                default: begin
                    state_nxt = ST_IDLE;
                    idx_nxt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_err   <= 1'b0;
            cmd_read  <= 1'b0;
            cmd_len   <= '0;
        end else begin
            cmd_valid <= (verdict == V_OK);
            cmd_err   <= (verdict == V_ERR);
            if (verdict == V_OK) begin
                cmd_read <= flags_nxt.dir_rd;
                cmd_len  <= flags_nxt.len[LEN_W-1:0];
            end
        end
    end
endmodule

// File: rtl/cbw_cfg_decoder.sv
`timescale 1ns/1ps
module cbw_cfg_decoder
    import cbw_cfg_pkg::*;
#(
    parameter int          MAX_LEN    = 255,
    parameter logic [7:0]  CFG_OPCODE = 8'h26,
    parameter logic [7:0]  MEM_SRC    = 8'h02,
    parameter logic [31:0] SIGNATURE  = 32'h43425355,
    localparam int         LEN_W      = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic [7:0]       vend_code,
    output logic             cmd_valid,
    output logic             cmd_read,
    output logic [LEN_W-1:0] cmd_len,
    output logic             cmd_err
);
    logic [IDX_W-1:0] idx;
    frame_flags_t     flags_nxt;

    cbw_field_check #(
        .SIGNATURE (SIGNATURE),
        .CFG_OPCODE(CFG_OPCODE),
        .MEM_SRC   (MEM_SRC)
    ) u_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (in_valid),
        .idx       (idx),
        .data      (in_data),
        .designator(vend_code),
        .flags_nxt (flags_nxt)
    );

    cbw_frame_fsm #(
        .MAX_LEN(MAX_LEN),
        .LEN_W  (LEN_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_last  (in_last),
        .flags_nxt(flags_nxt),
        .idx      (idx),
        .cmd_valid(cmd_valid),
        .cmd_err  (cmd_err),
        .cmd_read (cmd_read),
        .cmd_len  (cmd_len)
    );
endmodule

// File: rtl/cbw_cfg_decoder_chk.sv
`timescale 1ns/1ps
module cbw_cfg_decoder_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_last,
    input logic             cmd_valid,
    input logic             cmd_err,
    input logic             cmd_read,
    input logic [LEN_W-1:0] cmd_len
);
    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_err));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r2_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(in_valid && in_last));

    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> ($stable(cmd_len) && $stable(cmd_read)));

    a_r10_no_byte_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!cmd_valid && !cmd_err));
endmodule

bind cbw_cfg_decoder cbw_cfg_decoder_chk #(.LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_last  (in_last),
    .cmd_valid(cmd_valid),
    .cmd_err  (cmd_err),
    .cmd_read (cmd_read),
    .cmd_len  (cmd_len)
);

// File: tb/cbw_cfg_decoder_tb.sv
`timescale 1ns/1ps
module cbw_cfg_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic [7:0] vend_code = 8'hC5;
    logic       cmd_valid, cmd_read, cmd_err;
    logic [7:0] cmd_len;

    int checks = 0, errors = 0;
    int n_ok, n_err, err_at, got_len, got_rd;
    logic [7:0] fr [0:39];

    always #10 clk = ~clk;

    cbw_cfg_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .vend_code(vend_code), .cmd_valid(cmd_valid),
        .cmd_read(cmd_read), .cmd_len(cmd_len), .cmd_err(cmd_err)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic build(logic [31:0] len, bit rd);
        for (int i = 0; i < 40; i++) fr[i] = 8'h00;
        fr[0] = 8'h55; fr[1] = 8'h53; fr[2] = 8'h42; fr[3] = 8'h43;
        for (int i = 4; i < 8; i++) fr[i] = 8'hA0 + 8'(i);
        for (int i = 0; i < 4; i++) fr[8+i] = len[8*i +: 8];
        fr[12] = rd ? 8'h80 : 8'h00;
        fr[13] = 8'h00;
        fr[14] = 8'h10;
        fr[15] = vend_code;
        fr[16] = 8'h26;
        fr[18] = 8'h02;
    endtask

    task automatic sample(int p);
        if (cmd_valid) begin
            n_ok++;
            got_len = int'(cmd_len);
            got_rd  = int'(cmd_read);
        end
        if (cmd_err) begin
            n_err++;
            err_at = p;
        end
    endtask

    task automatic run(int n, bit gaps);
        int prev;
        prev = -1; n_ok = 0; n_err = 0; err_at = -1; got_len = -1; got_rd = -1;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk); sample(prev);
                in_valid = 1'b0; in_last = 1'b0; prev = -1;
            end
            @(negedge clk); sample(prev);
            in_valid = 1'b1; in_data = fr[i]; in_last = (i == n - 1); prev = i;
        end
        @(negedge clk); sample(prev);
        in_valid = 1'b0; in_last = 1'b0; prev = -1;
        @(negedge clk); sample(prev);
    endtask

    task automatic t_reset;
        chk("R1", "cmd_valid", int'(cmd_valid), 0);
        chk("R1", "cmd_err", int'(cmd_err), 0);
        chk("R1", "cmd_read", int'(cmd_read), 0);
        chk("R1", "cmd_len", int'(cmd_len), 0);
    endtask

    task automatic t_write_ok;
        build(32'd64, 1'b0);
        run(31, 1'b0);
        chk("R2", "pulses", n_ok, 1);
        chk("R2", "errors", n_err, 0);
        chk("R3", "cmd_read", got_rd, 0);
        chk("R4", "cmd_len", got_len, 64);
    endtask

    task automatic t_read_gaps;
        build(32'd255, 1'b1);
        fr[4] = 8'hFF; fr[13] = 8'h07; fr[14] = 8'h03;
        run(31, 1'b1);
        chk("R10", "pulses with gaps", n_ok, 1);
        chk("R11", "errors with odd tag/lun", n_err, 0);
        chk("R3", "cmd_read", got_rd, 1);
        chk("R4", "cmd_len at cap", got_len, 255);
        chk("R3", "cmd_read held", int'(cmd_read), 1);
    endtask

    task automatic t_len_over;
        build(32'd256, 1'b0);
        run(31, 1'b0);
        chk("R4", "len 256 pulses", n_ok, 0);
        chk("R4", "len 256 errors", n_err, 1);
        build(32'h0100_0000, 1'b1);
        run(31, 1'b0);
        chk("R4", "top-byte len errors", n_err, 1);
        chk("R4", "top-byte len pulses", n_ok, 0);
    endtask

    task automatic t_sig;
        build(32'd8, 1'b0);
        fr[2] = 8'h44;
        run(31, 1'b0);
        chk("R5", "bad signature errors", n_err, 1);
        chk("R5", "bad signature pulses", n_ok, 0);
    endtask

    task automatic t_short;
        build(32'd8, 1'b0);
        run(20, 1'b0);
        chk("R6", "short errors", n_err, 1);
        chk("R6", "short error position", err_at, 19);
        chk("R6", "short pulses", n_ok, 0);
        run(1, 1'b0);
        chk("R6", "one-byte error position", err_at, 0);
        chk("R6", "one-byte errors", n_err, 1);
    endtask

    task automatic t_long;
        build(32'd8, 1'b0);
        run(35, 1'b0);
        chk("R7", "long errors", n_err, 1);
        chk("R7", "long error position", err_at, 30);
        chk("R7", "long pulses", n_ok, 0);
        build(32'd9, 1'b1);
        run(31, 1'b0);
        chk("R7", "frame after flush pulses", n_ok, 1);
        chk("R7", "frame after flush len", got_len, 9);
    endtask

    task automatic t_desig;
        build(32'd8, 1'b0);
        fr[15] = vend_code ^ 8'h01;
        fr[16] = 8'h77;
        run(31, 1'b0);
        chk("R8", "foreign pulses", n_ok, 0);
        chk("R8", "foreign errors", n_err, 0);
        chk("R8", "cmd_len untouched", int'(cmd_len), 9);
    endtask

    task automatic t_fields;
        for (int p = 16; p <= 30; p++) begin
            build(32'd8, 1'b0);
            fr[p] = fr[p] ^ 8'h01;
            run(31, 1'b0);
            chk("R9", $sformatf("byte %0d errors", p), n_err, 1);
            chk("R9", $sformatf("byte %0d pulses", p), n_ok, 0);
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_write_ok;
        t_read_gaps;
        t_len_over;
        t_sig;
        t_short;
        t_long;
        t_desig;
        t_fields;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule